// File: doc/BRIEF.md
# Multithreaded Reorder Buffer Commit

This block holds the in-flight instructions of an out-of-order core that runs several hardware threads side by side. Every thread owns a private circular buffer of entries kept in program order. Each cycle the block accepts newly renamed instructions for every thread, hands back the index of the first slot it filled, takes completion reports from the execution units addressed by a thread number and a slot index, and decides which finished instructions leave the buffers.

Retirement is strictly in order inside a thread, but the threads compete for a single commit bandwidth shared by all of them. A round-robin pointer decides which thread is offered commit slots first. A mispredicted branch discards every younger entry of its own thread in the cycle it is reported, and the other threads do not notice. The branch itself stays and retires normally once it reaches the oldest position. The thread count and buffer depth are powers of two, and at least two threads are present.

Top module: `mt_rob_commit`

## Requirements
- R1: After reset every buffer is empty, no thread commits, every slot index output reads 0 and the round-robin pointer selects thread 0 first.
- R2: A thread's allocation request is a count from 0 to 2, and a value of 3 is treated as 2. The block accepts the smaller of the request and the free slots of that thread. It reports the accepted count and the index of the first slot written, which is the thread's tail. New entries fill consecutive slots modulo 16.
- R3: A thread with no free slot accepts nothing while other threads keep allocating normally. A thread is never given more slots than it has free.
- R4: A completion report marks the slot named by its thread number and index as finished. The report is ignored when that slot is not occupied or is already finished, and in that case it has no effect on completion or flushing.
- R5: Only a run of finished entries starting at the oldest entry of a thread can retire. The commit output of a thread gives the count retired together with the index of the oldest entry.
- R6: No more than 4 entries retire in one cycle, summed over all threads.
- R7: Commit slots are handed out thread by thread in rotation. Each thread takes as many as it can before the next thread is served. The rotation starts at the thread after the first thread that retired anything in the previous cycle, and stays where it was after a cycle with no retirement.
- R8: A completion with the mispredict flag set removes all entries younger than that branch from its thread in the same cycle, so the thread's next tail is the branch index plus one. In that cycle the thread accepts no allocation, and the other threads are unaffected.
- R9: When several accepted mispredict reports hit one thread in the same cycle, the one closest to the oldest entry decides the flush.
- R10: The mispredicted branch remains in its buffer and retires when it becomes the oldest entry. Removed wrong-path entries never retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | NTHR*2 | Per-thread requested allocation count |
| alloc_acc | output | NTHR*2 | Per-thread accepted allocation count |
| alloc_idx | output | NTHR*4 | Per-thread index of first slot allocated (tail) |
| cmpl_vld | input | CMPL_N | Completion report valid, one per port |
| cmpl_tid | input | CMPL_N*2 | Thread number of each completion |
| cmpl_idx | input | CMPL_N*4 | Slot index of each completion |
| cmpl_mis | input | CMPL_N | Completion reports a mispredicted branch |
| cmt_cnt | output | NTHR*3 | Per-thread number of entries retiring this cycle |
| cmt_idx | output | NTHR*4 | Per-thread index of the oldest entry (head) |

## Verification
A behavioural model tracks occupancy and finished slots for each thread and is compared with the ports every cycle across several stimulus patterns. The first pattern drives only one thread to fill its buffer, which separates a per-thread stall from a global one. The second completes entries youngest first, which shows that retirement waits for the oldest entry. A dense pattern with every thread ready shows the shared cap of four and the rotation order. The last random pattern mixes mispredicts and stray completion reports on several ports, which checks the flush point, the choice between competing flushes, and that reports to empty or finished slots do nothing.

// File: rtl/mt_rob_commit.sv
module mt_rob_commit #(
  parameter int NTHR     = 4,
  parameter int DEPTH    = 16,
  parameter int ALLOC_W  = 2,
  parameter int COMMIT_W = 4,
  parameter int CMPL_N   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTHR*$clog2(ALLOC_W+1)-1:0]  alloc_req,
  output logic [NTHR*$clog2(ALLOC_W+1)-1:0]  alloc_acc,
  output logic [NTHR*$clog2(DEPTH)-1:0]      alloc_idx,
  input  logic [CMPL_N-1:0]                  cmpl_vld,
  input  logic [CMPL_N*$clog2(NTHR)-1:0]     cmpl_tid,
  input  logic [CMPL_N*$clog2(DEPTH)-1:0]    cmpl_idx,
  input  logic [CMPL_N-1:0]                  cmpl_mis,
  output logic [NTHR*$clog2(COMMIT_W+1)-1:0] cmt_cnt,
  output logic [NTHR*$clog2(DEPTH)-1:0]      cmt_idx
);
  localparam int TW = $clog2(NTHR);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = $clog2(ALLOC_W+1);
  localparam int KW = $clog2(COMMIT_W+1);

  logic [IW-1:0]    head_q [NTHR];
  logic [IW-1:0]    tail_q [NTHR];
  logic [CW-1:0]    cnt_q  [NTHR];
  logic [DEPTH-1:0] done_q [NTHR];
  logic [DEPTH-1:0] mark   [NTHR];
  logic [NTHR-1:0]  fl_hit;
  logic [IW-1:0]    fl_off [NTHR];
  logic [KW-1:0]    rdy    [NTHR];
  logic [KW-1:0]    grant  [NTHR];
  logic [AW-1:0]    acc    [NTHR];
  logic [TW-1:0]    rr_q, rr_n;
  logic [KW+TW:0]   tot_cmt;

  always_comb begin : cmpl_scan
    logic [TW-1:0] ct;
    logic [IW-1:0] ci, co;
    ct = '0; ci = '0; co = '0;
    fl_hit = '0;
    for (int t = 0; t < NTHR; t++) begin
      fl_off[t] = '0;
      mark[t]   = '0;
    end
    for (int c = 0; c < CMPL_N; c++) begin
      ct = cmpl_tid[c*TW +: TW];
      ci = cmpl_idx[c*IW +: IW];
      co = ci - head_q[ct];
      if (cmpl_vld[c] && CW'(co) < cnt_q[ct] && !done_q[ct][ci]) begin
        mark[ct][ci] = 1'b1;
        if (cmpl_mis[c] && (!fl_hit[ct] || co < fl_off[ct])) begin
          fl_hit[ct] = 1'b1;
          fl_off[ct] = co;
        end
      end
    end
  end

  always_comb begin : retire_pick
    logic [KW-1:0] rem;
    logic [TW-1:0] tt;
    logic [IW-1:0] p;
    logic run, found;
    rem = KW'(COMMIT_W); tt = '0; p = '0; run = 1'b0; found = 1'b0;
    rr_n = rr_q;
    for (int t = 0; t < NTHR; t++) begin
      rdy[t]   = '0;
      grant[t] = '0;
      run      = 1'b1;
      for (int k = 0; k < COMMIT_W; k++) begin
        p = head_q[t] + IW'(k);
        if (run && CW'(k) < cnt_q[t] && done_q[t][p]) rdy[t] = rdy[t] + KW'(1);
        else run = 1'b0;
      end
    end
    for (int j = 0; j < NTHR; j++) begin
      tt = rr_q + TW'(j);
      grant[tt] = (rdy[tt] < rem) ? rdy[tt] : rem;
      rem = rem - grant[tt];
      if (grant[tt] != '0 && !found) begin
        found = 1'b1;
        rr_n  = tt + TW'(1);
      end
    end
  end

  always_comb begin : alloc_calc
    logic [AW-1:0] r;
    logic [CW-1:0] fr;
    r = '0; fr = '0;
    for (int t = 0; t < NTHR; t++) begin
      r = alloc_req[t*AW +: AW];
      if (r > AW'(ALLOC_W)) r = AW'(ALLOC_W);
      fr = CW'(DEPTH) - cnt_q[t];
      acc[t] = fl_hit[t] ? '0 : ((CW'(r) <= fr) ? r : AW'(fr));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int t = 0; t < NTHR; t++) begin
        head_q[t] <= '0;
        tail_q[t] <= '0;
        cnt_q[t]  <= '0;
        done_q[t] <= '0;
      end
    end else begin
      rr_q <= rr_n;
      for (int t = 0; t < NTHR; t++) begin
        head_q[t] <= head_q[t] + IW'(grant[t]);
        if (fl_hit[t]) begin
          tail_q[t] <= head_q[t] + fl_off[t] + IW'(1);
          cnt_q[t]  <= CW'(fl_off[t]) + CW'(1) - CW'(grant[t]);
        end else begin
          tail_q[t] <= tail_q[t] + IW'(acc[t]);
          cnt_q[t]  <= cnt_q[t] + CW'(acc[t]) - CW'(grant[t]);
        end
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(IW'(IW'(i) - tail_q[t])) < CW'(acc[t])) done_q[t][i] <= 1'b0;
          else if (mark[t][i]) done_q[t][i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    tot_cmt = '0;
    for (int t = 0; t < NTHR; t++) tot_cmt = tot_cmt + (KW+TW+1)'(grant[t]);
  end

  // R6
  commit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot_cmt <= (KW+TW+1)'(COMMIT_W));

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    assign alloc_acc[g*AW +: AW] = acc[g];
    assign alloc_idx[g*IW +: IW] = tail_q[g];
    assign cmt_cnt[g*KW +: KW]   = grant[g];
    assign cmt_idx[g*IW +: IW]   = head_q[g];

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CW'(DEPTH));
    // R2
    alloc_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(acc[g]) + cnt_q[g]) <= CW'(DEPTH));
    // R5
    head_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] != '0) |-> done_q[g][head_q[g]]);
    // R8
    flush_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_hit[g] |=> (cnt_q[g] <= CW'($past(fl_off[g])) + CW'(1)));
  end
endmodule

// File: tb/mt_rob_commit_bench.sv
`timescale 1ns/1ps
module mt_rob_commit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  alloc_req = '0;
  logic [7:0]  alloc_acc;
  logic [15:0] alloc_idx;
  logic [3:0]  cmpl_vld = '0;
  logic [7:0]  cmpl_tid = '0;
  logic [15:0] cmpl_idx = '0;
  logic [3:0]  cmpl_mis = '0;
  logic [11:0] cmt_cnt;
  logic [15:0] cmt_idx;

  always #4 clk = ~clk;

  mt_rob_commit u_mt_rob_commit (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_acc(alloc_acc), .alloc_idx(alloc_idx),
    .cmpl_vld(cmpl_vld), .cmpl_tid(cmpl_tid), .cmpl_idx(cmpl_idx), .cmpl_mis(cmpl_mis),
    .cmt_cnt(cmt_cnt), .cmt_idx(cmt_idx)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int m_head [4];
  int m_cnt  [4];
  bit m_done [4][16];
  int m_rr;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int rdy[4], ec[4], ea[4], fo[4], otail[4];
    bit fl[4];
    bit mk[4][16];
    int rem, first, t, i, off, r;
    bit run;
    for (int a = 0; a < 4; a++) begin
      fl[a] = 0; fo[a] = 0; rdy[a] = 0;
      for (int b = 0; b < 16; b++) mk[a][b] = 0;
      run = 1;
      for (int k = 0; k < 4; k++)
        if (run && k < m_cnt[a] && m_done[a][(m_head[a]+k)%16]) rdy[a]++;
        else run = 0;
    end
    rem = 4; first = -1;
    for (int j = 0; j < 4; j++) begin
      t = (m_rr + j) % 4;
      ec[t] = (rdy[t] < rem) ? rdy[t] : rem;
      rem -= ec[t];
      if (ec[t] > 0 && first < 0) first = t;
    end
    for (int c = 0; c < 4; c++) begin
      if (cmpl_vld[c]) begin
        t = cmpl_tid[c*2 +: 2];
        i = cmpl_idx[c*4 +: 4];
        off = (i - m_head[t] + 16) % 16;
        if (off < m_cnt[t] && !m_done[t][i]) begin
          mk[t][i] = 1;
          if (cmpl_mis[c] && (!fl[t] || off < fo[t])) begin
            fl[t] = 1; fo[t] = off;
          end
        end
      end
    end
    for (int a = 0; a < 4; a++) begin
      r = alloc_req[a*2 +: 2];
      if (r > 2) r = 2;
      ea[a] = fl[a] ? 0 : ((r < 16 - m_cnt[a]) ? r : 16 - m_cnt[a]);
      chk("R5 R6 R7 R10 R4 commit count", cmt_cnt[a*3 +: 3], ec[a]);
      chk("R5 oldest index", cmt_idx[a*4 +: 4], m_head[a]);
      chk("R2 R3 R8 accepted count", alloc_acc[a*2 +: 2], ea[a]);
      chk("R2 R8 R9 tail index", alloc_idx[a*4 +: 4], (m_head[a] + m_cnt[a]) % 16);
    end
    for (int a = 0; a < 4; a++) begin
      otail[a] = (m_head[a] + m_cnt[a]) % 16;
      for (int b = 0; b < 16; b++) if (mk[a][b]) m_done[a][b] = 1;
      m_head[a] = (m_head[a] + ec[a]) % 16;
      if (fl[a]) m_cnt[a] = fo[a] + 1 - ec[a];
      else m_cnt[a] = m_cnt[a] + ea[a] - ec[a];
      for (int n = 0; n < ea[a]; n++) m_done[a][(otail[a] + n) % 16] = 0;
    end
    if (first >= 0) m_rr = (first + 1) % 4;
  endtask

  task automatic drive(input int mode);
    int t, off, pick;
    alloc_req = '0; cmpl_vld = '0; cmpl_mis = '0; cmpl_tid = '0; cmpl_idx = '0;
    case (mode)
      1: begin
        alloc_req[1:0] = 2'd3;
        alloc_req[3:2] = 2'($urandom % 2);
      end
      2: begin
        pick = -1;
        for (int k = m_cnt[0] - 1; k >= 0; k--)
          if (pick < 0 && !m_done[0][(m_head[0]+k)%16]) pick = k;
        if (pick >= 0) begin
          cmpl_vld[0] = 1'b1;
          cmpl_idx[3:0] = 4'((m_head[0] + pick) % 16);
        end
        cmpl_vld[3] = 1'b1;
        cmpl_tid[7:6] = 2'd2;
        cmpl_idx[15:12] = 4'($urandom);
      end
      3, 4: begin
        for (int a = 0; a < 4; a++) alloc_req[a*2 +: 2] = 2'($urandom);
        for (int c = 0; c < 4; c++) begin
          t = $urandom % 4;
          cmpl_tid[c*2 +: 2] = 2'(t);
          if (m_cnt[t] > 0 && ($urandom % 100) < 85) begin
            off = $urandom % m_cnt[t];
            cmpl_idx[c*4 +: 4] = 4'((m_head[t] + off) % 16);
          end else cmpl_idx[c*4 +: 4] = 4'($urandom);
          cmpl_vld[c] = ($urandom % 100) < 80;
          cmpl_mis[c] = (mode == 4) && (($urandom % 100) < 12);
        end
      end
      default: ;
    endcase
  endtask

  task automatic run(input int n, input int mode);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive(mode);
      #1;
      model_step();
    end
  endtask

  initial begin
    for (int a = 0; a < 4; a++) begin
      m_head[a] = 0; m_cnt[a] = 0;
      for (int b = 0; b < 16; b++) m_done[a][b] = 0;
    end
    m_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 no commit in reset", int'(cmt_cnt), 0);
    chk("R1 head indexes", int'(cmt_idx), 0);
    chk("R1 tail indexes", int'(alloc_idx), 0);
    rst_n = 1'b1;
    run(30, 1);   // fill thread 0, R3 stall
    run(40, 2);   // youngest-first completion, R5
    run(20, 0);
    run(600, 3);  // dense, R6 R7
    run(2000, 4); // mispredicts, R8 R9 R10 R4
    run(40, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule